// File: doc/BRIEF.md
# Byte-Loaded Dot-Matrix Display Controller

This block refreshes a single-colour LED dot-matrix panel of 128 columns by 32 rows on its own. A host loads the picture through a byte-wide write port, one byte at a time and at whatever rate suits it. The picture is kept in on-chip synchronous RAM. A row scanner walks through the panel from that RAM, so the host never has to keep pace with the refresh. Each pixel carries two bits and has four brightness levels. Brightness comes from binary-weighted bit planes: within one row period, plane p is shown for 2^p scan ticks.

The board brings out fewer column lines than the panel has. For that reason the scan side works on a 64 by 64 logical array. Each physical row is split over two logical rows. The even logical row 2r drives physical row r, columns 0 to 63. The odd logical row 2r+1 drives columns 64 to 127 of the same physical row. The outputs are a one-hot logical row select and 64 column lines. The first scan tick of every row is dark, so no pixels bleed into a neighbouring row while the row select moves.

Top module: `dmd_matrix_ctrl`

## Requirements
- R1: While reset is asserted, `row_sel_o` has only bit 0 set and `col_o` is all zero.
- R2: For the NUM_WORDS = BPP × 2 × PHYS_ROWS cycles after reset release, the block sweeps the frame store to zero and `col_o` stays zero. Until a pixel is written, every pixel reads as dark.
- R3: A host write accepted during that clearing sweep is discarded and leaves the picture unchanged.
- R4: Byte address = plane × (PHYS_ROWS × PHYS_COLS/8) + physical_row × (PHYS_COLS/8) + column/8. In each byte, bit 7 is the leftmost of eight adjacent pixels and bit 0 the rightmost. Plane 0 carries the weight-1 bit of each pixel and plane 1 the weight-2 bit.
- R5: Logical row 2r shows physical columns 0 to PHYS_COLS/2−1 of physical row r. Logical row 2r+1 shows the remaining columns of that row. `col_o` bit j is logical column j counted from the left.
- R6: A write whose address is at or above BPP × PHYS_ROWS × PHYS_COLS/8 changes no pixel.
- R7: `row_sel_o` always has exactly one bit set. On each change it moves from logical row L to row (L+1) mod 2×PHYS_ROWS.
- R8: Every row period lasts 2^BPP × PRESCALE clock cycles, apart from the first one after reset. It starts with one dark tick of PRESCALE cycles. After that, plane p is shown for 2^p × PRESCALE cycles, in ascending plane order.
- R9: `col_o` is zero in the cycle in which `row_sel_o` changes.
- R10: During one row period, a pixel with level v (0 to 2^BPP−1) drives its column line high for exactly v × PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host byte-write strobe, sampled on the rising clock edge |
| wr_addr_i | input | ADDR_W | Host byte address (see R4) |
| wr_data_i | input | 8 | Host pixel byte, MSB leftmost |
| row_sel_o | output | 2×PHYS_ROWS | One-hot logical row select |
| col_o | output | PHYS_COLS/2 | Column drive for the selected logical row |

## Verification
The properties assume that PRESCALE and the clock stay fixed after reset. They also assume that reset is held for at least one edge, because the row-period counter in the checker is trusted only from the second row change onward. No property depends on the host write port. The bench therefore writes freely, including during the clearing sweep and beyond the address map. It compares picture content only in frames that are scanned after the last write, so each logical row and plane is sampled on every cycle against a frame that is not changing.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

   // Clearing sweep state of the frame store.
   typedef enum logic {
      CLR_SWEEP = 1'b1,
      CLR_IDLE  = 1'b0
   } clr_state_e;

   // Scan slot s (1 .. 2^planes-1) belongs to plane floor(log2(s)).
   // Slot 0 is the dark slot and maps to plane 0; it is masked elsewhere.
   function automatic int unsigned slot_to_plane(input int unsigned slot);
      int unsigned p;
      p = 0;
      for (int i = 0; i < 31; i++) begin
         if (slot >= (32'd1 << i)) p = i;
      end
      return p;
   endfunction

endpackage

// File: rtl/dmd_host_decode.sv
module dmd_host_decode #(
   parameter int PHYS_ROWS = 32,
   parameter int PHYS_COLS = 128,
   parameter int BPP       = 2,
   parameter int ADDR_W    = 11,
   parameter int WORD_AW   = 7,
   parameter int LANES     = 8
)(
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               block_i,
   output logic [LANES-1:0]   lane_we_o,
   output logic [WORD_AW-1:0] word_o
);

   localparam int BYTES_PER_ROW = PHYS_COLS / 8;
   localparam int PLANE_BYTES   = PHYS_ROWS * BYTES_PER_ROW;
   localparam int MAP_BYTES     = BPP * PLANE_BYTES;
   localparam int LOG_ROWS      = 2 * PHYS_ROWS;

   int unsigned a, plane, prow, cb, half, lane;
   logic        in_map;

   always_comb begin
      a      = 32'(addr_i);
      in_map = (a < MAP_BYTES);
      plane  = a / PLANE_BYTES;
      prow   = (a / BYTES_PER_ROW) % PHYS_ROWS;
      cb     = a % BYTES_PER_ROW;
      half   = cb / LANES;
      lane   = cb % LANES;
      word_o = WORD_AW'(plane * LOG_ROWS + prow * 2 + half);
      if (wr_en_i && in_map && !block_i)
         lane_we_o = LANES'(1) << lane;
      else
         lane_we_o = '0;
   end

endmodule

// File: rtl/dmd_frame_ram.sv
module dmd_frame_ram #(
   parameter int LANES     = 8,
   parameter int NUM_WORDS = 128,
   parameter int WORD_AW   = 7
)(
   input  logic               clk,
   input  logic [LANES-1:0]   we_i,
   input  logic [WORD_AW-1:0] waddr_i,
   input  logic [7:0]         wdata_i,
   input  logic [WORD_AW-1:0] raddr_i,
   output logic [LANES*8-1:0] rdata_o
);

   // One byte-wide simple dual-port RAM per lane. A read and a write to
   // the same word in one cycle give the reader the old content.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [NUM_WORDS];
      logic [7:0] q;

      always_ff @(posedge clk) begin
         if (we_i[l]) mem[waddr_i] <= wdata_i;
         q <= mem[raddr_i];
      end

      assign rdata_o[l*8 +: 8] = q;
   end

endmodule

// File: rtl/dmd_row_scan.sv
module dmd_row_scan #(
   parameter int LOG_ROWS = 64,
   parameter int BPP      = 2,
   parameter int PRESCALE = 4096
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_i,
   output logic [$clog2(LOG_ROWS)-1:0] row_o,
   output logic [BPP-1:0]              slot_o
);

   localparam int ROW_W  = $clog2(LOG_ROWS);
   localparam int SLOT_W = BPP;
   localparam int SLOTS  = 1 << BPP;

   logic tick;

   if (PRESCALE == 1) begin : g_nodiv
      assign tick = run_i;
   end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q <= '0;
         else if (run_i)
            div_q <= (div_q == PW'(PRESCALE - 1)) ? '0 : div_q + 1'b1;
      end

      assign tick = run_i && (div_q == PW'(PRESCALE - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_o  <= '0;
         slot_o <= '0;
      end else if (tick) begin
         if (slot_o == SLOT_W'(SLOTS - 1)) begin
            slot_o <= '0;
            row_o  <= (row_o == ROW_W'(LOG_ROWS - 1)) ? '0 : row_o + 1'b1;
         end else begin
            slot_o <= slot_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dmd_matrix_ctrl.sv
module dmd_matrix_ctrl
   import dmd_pkg::*;
#(
   parameter int PHYS_COLS = 128,
   parameter int PHYS_ROWS = 32,
   parameter int BPP       = 2,
   parameter int PRESCALE  = 4096,
   parameter int ADDR_W    = 11,
   parameter int CLK_HZ    = 100_000_000,
   parameter int MIN_FPS   = 60
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [ADDR_W-1:0]      wr_addr_i,
   input  logic [7:0]             wr_data_i,
   output logic [2*PHYS_ROWS-1:0] row_sel_o,
   output logic [PHYS_COLS/2-1:0] col_o
);

   localparam int LOG_ROWS  = 2 * PHYS_ROWS;
   localparam int LOG_COLS  = PHYS_COLS / 2;
   localparam int LANES     = LOG_COLS / 8;
   localparam int NUM_WORDS = BPP * LOG_ROWS;
   localparam int WORD_AW   = $clog2(NUM_WORDS);
   localparam int ROW_W     = $clog2(LOG_ROWS);
   localparam int SLOT_W    = BPP;
   localparam int MAP_BYTES = BPP * PHYS_ROWS * (PHYS_COLS / 8);
   localparam longint FRAME_CYC = longint'(PRESCALE) * LOG_ROWS * (longint'(1) << BPP);

   // Elaboration-time parameter checks
   if (PHYS_COLS < 32 || (PHYS_COLS % 16) != 0) begin : g_bad_cols
      $error("PHYS_COLS must be a multiple of 16 and at least 32");
   end
   if (PHYS_ROWS < 1) begin : g_bad_rows
      $error("PHYS_ROWS must be positive");
   end
   if (BPP < 1 || BPP > 8) begin : g_bad_bpp
      $error("BPP must lie in 1..8");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("PRESCALE must be positive");
   end
   if ((longint'(1) << ADDR_W) < MAP_BYTES) begin : g_bad_addr
      $error("ADDR_W too narrow for the frame map");
   end
   if (longint'(CLK_HZ) / FRAME_CYC < MIN_FPS) begin : g_bad_fps
      $error("PRESCALE too large for the minimum frame rate");
   end

   // Clearing sweep of the frame store after reset
   clr_state_e         clr_q;
   logic [WORD_AW-1:0] clr_idx;
   logic               clearing;

   assign clearing = (clr_q == CLR_SWEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q   <= CLR_SWEEP;
         clr_idx <= '0;
      end else if (clearing) begin
         if (clr_idx == WORD_AW'(NUM_WORDS - 1))
            clr_q <= CLR_IDLE;
         else
            clr_idx <= clr_idx + 1'b1;
      end
   end

   // Host write decode
   logic [LANES-1:0]   host_we;
   logic [WORD_AW-1:0] host_word;

   dmd_host_decode #(
      .PHYS_ROWS (PHYS_ROWS),
      .PHYS_COLS (PHYS_COLS),
      .BPP       (BPP),
      .ADDR_W    (ADDR_W),
      .WORD_AW   (WORD_AW),
      .LANES     (LANES)
   ) decode_i (
      .wr_en_i   (wr_en_i),
      .addr_i    (wr_addr_i),
      .block_i   (clearing),
      .lane_we_o (host_we),
      .word_o    (host_word)
   );

   // Row scanner
   logic [ROW_W-1:0]  row_q;
   logic [SLOT_W-1:0] slot_q;

   dmd_row_scan #(
      .LOG_ROWS (LOG_ROWS),
      .BPP      (BPP),
      .PRESCALE (PRESCALE)
   ) scan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (!clearing),
      .row_o  (row_q),
      .slot_o (slot_q)
   );

   // Frame store: one word holds one logical row of one plane
   logic [LANES-1:0]   ram_we;
   logic [WORD_AW-1:0] ram_waddr;
   logic [7:0]         ram_wdata;
   logic [WORD_AW-1:0] rd_word;
   logic [LOG_COLS-1:0] rd_data;

   assign ram_we    = clearing ? '1 : host_we;
   assign ram_waddr = clearing ? clr_idx : host_word;
   assign ram_wdata = clearing ? 8'h00 : wr_data_i;
   assign rd_word   = WORD_AW'(slot_to_plane(32'(slot_q)) * LOG_ROWS + 32'(row_q));

   dmd_frame_ram #(
      .LANES     (LANES),
      .NUM_WORDS (NUM_WORDS),
      .WORD_AW   (WORD_AW)
   ) ram_i (
      .clk     (clk),
      .we_i    (ram_we),
      .waddr_i (ram_waddr),
      .wdata_i (ram_wdata),
      .raddr_i (rd_word),
      .rdata_o (rd_data)
   );

   // Byte MSB is the leftmost pixel: reverse bits inside each lane
   logic [LOG_COLS-1:0] col_img;

   for (genvar l = 0; l < LANES; l++) begin : g_remap
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign col_img[l*8 + i] = rd_data[l*8 + 7 - i];
      end
   end

   // Align row select with the RAM read latency
   logic [ROW_W-1:0]  row_d1;
   logic [SLOT_W-1:0] slot_d1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_d1    <= '0;
         slot_d1   <= '0;
         row_sel_o <= LOG_ROWS'(1);
         col_o     <= '0;
      end else begin
         row_d1    <= row_q;
         slot_d1   <= slot_q;
         row_sel_o <= LOG_ROWS'(1) << row_d1;
         col_o     <= (slot_d1 == '0) ? '0 : col_img;
      end
   end

endmodule

// File: rtl/dmd_matrix_ctrl_chk.sv
module dmd_matrix_ctrl_chk #(
   parameter int LOG_ROWS = 64,
   parameter int LOG_COLS = 64,
   parameter int BPP      = 2,
   parameter int PRESCALE = 4096
)(
   input logic                clk,
   input logic                rst_n,
   input logic [LOG_ROWS-1:0] row_sel_o,
   input logic [LOG_COLS-1:0] col_o
);

   localparam int NUM_WORDS = BPP * LOG_ROWS;
   localparam int ROW_CYC   = (1 << BPP) * PRESCALE;

   logic [LOG_ROWS-1:0] row_prev;
   logic [31:0]         dwell;
   logic [31:0]         age;
   logic                seen;
   logic                row_moved;

   assign row_moved = (row_sel_o != row_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_prev <= LOG_ROWS'(1);
         dwell    <= '0;
         age      <= '0;
         seen     <= 1'b0;
      end else begin
         row_prev <= row_sel_o;
         dwell    <= row_moved ? 32'd1 : dwell + 32'd1;
         if (row_moved) seen <= 1'b1;
         if (age != '1) age <= age + 32'd1;
      end
   end

   // R7
   row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_sel_o) == 1);

   // R7
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_moved |-> row_sel_o == {row_prev[LOG_ROWS-2:0], row_prev[LOG_ROWS-1]});

   // R8
   row_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && row_moved) |-> dwell == 32'(ROW_CYC));

   // R9
   blank_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_moved |-> col_o == '0);

   // R2
   dark_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age < 32'(NUM_WORDS)) |-> col_o == '0);

endmodule

bind dmd_matrix_ctrl dmd_matrix_ctrl_chk #(
   .LOG_ROWS (LOG_ROWS),
   .LOG_COLS (LOG_COLS),
   .BPP      (BPP),
   .PRESCALE (PRESCALE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_sel_o (row_sel_o),
   .col_o     (col_o)
);

// File: tb/dmd_matrix_ctrl_tb_top.sv
module dmd_matrix_ctrl_tb_top;

   localparam int PC  = 32;
   localparam int PR  = 4;
   localparam int NP  = 2;
   localparam int PS  = 4;
   localparam int AW  = 7;
   localparam int LR  = 2 * PR;
   localparam int LC  = PC / 2;
   localparam int BPR = PC / 8;
   localparam int MAP = NP * PR * BPR;
   localparam int SL  = 1 << NP;
   localparam int RC  = SL * PS;
   localparam int NW  = NP * LR;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [LR-1:0] row_sel;
   logic [LC-1:0] col;

   int checks = 0;
   int errors = 0;
   logic [7:0] shadow [MAP];

   always #5 clk = ~clk;

   dmd_matrix_ctrl #(
      .PHYS_COLS (PC),
      .PHYS_ROWS (PR),
      .BPP       (NP),
      .PRESCALE  (PS),
      .ADDR_W    (AW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .row_sel_o (row_sel),
      .col_o     (col)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int plane_of(input int s);
      int p = 0;
      while ((2 << p) <= s) p++;
      return p;
   endfunction

   function automatic logic [LC-1:0] exp_cols(input int lrow, input int s);
      logic [LC-1:0] v = '0;
      if (s == 0) return v;
      for (int j = 0; j < LC; j++) begin
         int c = (lrow % 2) * LC + j;
         int a = plane_of(s) * PR * BPR + (lrow / 2) * BPR + c / 8;
         v[j] = shadow[a][7 - (c % 8)];
      end
      return v;
   endfunction

   function automatic int level_of(input int lrow, input int j);
      int lv = 0;
      int c  = (lrow % 2) * LC + j;
      for (int p = 0; p < NP; p++) begin
         int a = p * PR * BPR + (lrow / 2) * BPR + c / 8;
         lv += int'(shadow[a][7 - (c % 8)]) << p;
      end
      return lv;
   endfunction

   task automatic write_byte(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      if (a < MAP) shadow[a] = d;
   endtask

   // Scans one whole frame cycle by cycle, starting at the first cycle of row 0.
   task automatic scan_frame(input string req);
      @(negedge clk);
      while (row_sel !== (LR'(1) << (LR - 1))) @(negedge clk);
      while (row_sel !== LR'(1)) @(negedge clk);
      for (int L = 0; L < LR; L++) begin
         int lit [LC];
         bit held = 1'b1;
         for (int j = 0; j < LC; j++) lit[j] = 0;
         for (int k = 0; k < RC; k++) begin
            logic [LC-1:0] e = exp_cols(L, k / PS);
            if (row_sel !== (LR'(1) << L)) held = 1'b0;
            if (k / PS == 0)
               check(col === e, "R9", "dark slot", col, e);
            else
               check(col === e, req, "columns", col, e);
            for (int j = 0; j < LC; j++) if (col[j] === 1'b1) lit[j]++;
            @(negedge clk);
         end
         check(held, "R8", "row period", L, L);
         check(row_sel === (LR'(1) << ((L + 1) % LR)), "R7", "next row",
               row_sel, LR'(1) << ((L + 1) % LR));
         for (int j = 0; j < LC; j++)
            check(lit[j] == level_of(L, j) * PS, "R10", "lit cycles",
                  lit[j], level_of(L, j) * PS);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < MAP; a++) shadow[a] = 8'h00;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(row_sel === LR'(1), "R1", "row select in reset", row_sel, 1);
      check(col === '0, "R1", "columns in reset", col, 0);
      rst_n = 1'b1;

      // R2 / R3: writes during the clearing sweep, outputs must stay dark
      for (int k = 0; k < NW; k++) begin
         wr_en   = (k < 8);
         wr_addr = AW'(k * 4);
         wr_data = 8'hA5;
         check(col === '0, "R2", "dark during clear", col, 0);
         @(negedge clk);
      end
      wr_en = 1'b0;
      repeat (4) @(negedge clk);
      scan_frame("R3");

      // R4: arithmetic pattern over the whole map
      for (int a = 0; a < MAP; a++) write_byte(a, 8'((a * 37 + 11) & 8'hFF));
      scan_frame("R4");

      // R6: writes above the map must not alias into it
      for (int a = MAP; a < (1 << AW); a += 5) write_byte(a, ~shadow[a % MAP]);
      scan_frame("R6");

      // R10: uniform level 1 and level 2
      for (int a = 0; a < MAP; a++) write_byte(a, (a < MAP / 2) ? 8'hFF : 8'h00);
      scan_frame("R10");
      for (int a = 0; a < MAP; a++) write_byte(a, (a < MAP / 2) ? 8'h00 : 8'hFF);
      scan_frame("R10");

      // R5: single pixel in the right half of physical row 1, level 3
      for (int a = 0; a < MAP; a++) write_byte(a, 8'h00);
      write_byte(1 * BPR + 2, 8'h80);
      write_byte(PR * BPR + 1 * BPR + 2, 8'h80);
      scan_frame("R5");

      // R5: distinct content per row and half
      for (int a = 0; a < MAP; a++) write_byte(a, 8'(a ^ 8'h3C));
      scan_frame("R5");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule